// File: doc/BRIEF.md
# Frame Overhead and Checksum Unit

This block builds the overhead bytes that a serial aggregate link carries in its reserved timeslots. A frame has 256 byte timeslots. The bytes in eight of these slots are made here: a fixed alignment code, a byte that packs sampled low-rate asynchronous levels together with the two synchronisation flags, a checksum of the previous transmitted frame, three reserved fillers, and the two bytes of the local error count. An external multiplexer asks for the byte of the current slot. It also returns each transmitted byte so that the running checksum can follow the stream.

The receive half recomputes the same checksum over the incoming aggregate. It compares the result with the checksum byte that the far end sends one frame later and counts each mismatch in a saturating counter. That counter is what the transmit half reports in its error-count slots. The receive half also picks up the error count that the far end reports in the same slot pair.

The checksum is an 8-bit sum with end-around carry. The carry out of each addition is added into the next one. Slot 0, which carries the alignment code, is left out of the sum.

Top module: `frame_ovh_unit`

## Requirements
- R1: After reset the checksum byte, the published asynchronous samples, the local error count and the remote error count are all zero.
- R2: Timeslot 0 gives the alignment byte (default 8'hA5). Timeslots 24, 32 and 40 give 8'h00. Timeslots 0, 8, 16, 24, 32, 40, 48 and 56 raise `ovh_hit`. Any other slot gives `ovh_hit`=0 and `ovh_byte`=0.
- R3: Timeslot 16 carries the checksum of the previous frame. That checksum starts at zero after each slot 0 and then takes, for each of slots 1 to 255, acc = low 8 bits of (acc + byte + carry), with carry set to bit 8 of that sum. Whatever the accumulator holds is latched at the next slot 0. The carry left over from the last addition is dropped.
- R4: The timeslot 8 byte is laid out as follows: bit 7 = `far_sync`, bit 6 = `near_sync` (both as driven during that slot), bits 5:2 = the four fast samples, bits 1:0 = `slow_in[1:0]`.
- R5: The slow inputs are sampled at slot 0. The fast input is sampled at slots 0, 64, 128 and 192, landing in byte bits 5, 4, 3 and 2 in that order. A frame's samples are published at the following slot 0.
- R6: Timeslot 48 gives bits 15:8 of the local error count. Timeslot 56 gives bits 7:0 as they stood when slot 48 was sent, even if the count has changed since.
- R7: The local error count increments by one when receive slot 16 carries a byte that differs from the receive checksum of the previous frame. A comparison is made only after two receive slot-0 events since reset.
- R8: The local error count saturates at 16'hFFFF.
- R9: The remote error count becomes {receive byte of slot 48, receive byte of slot 56} when slot 56 is received, and holds otherwise.
- R10: A slot presented with its valid input low changes no state, and on the transmit side it gives `ovh_hit`=0 and `ovh_byte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per valid cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Transmit slot present this cycle |
| tx_slot | input | 8 | Transmit timeslot number |
| tx_byte | input | 8 | Byte actually transmitted in this slot |
| slow_in | input | 2 | Levels sampled once per frame |
| fast_in | input | 1 | Level sampled four times per frame |
| far_sync | input | 1 | Far-end receiver in frame sync |
| near_sync | input | 1 | Near-end receiver in frame sync |
| rx_valid | input | 1 | Receive slot present this cycle |
| rx_slot | input | 8 | Receive timeslot number |
| rx_byte | input | 8 | Received byte |
| ovh_hit | output | 1 | Current transmit slot is an overhead slot |
| ovh_byte | output | 8 | Overhead byte for the current transmit slot |
| local_err_cnt | output | 16 | Saturating count of checksum mismatches |
| remote_err_cnt | output | 16 | Error count reported by the far end |

## Verification
The hardest state to reach is a saturated error counter, because each increment normally costs a whole received frame. The stimulus sends receive frames that hold only slots 0 and 16 and deliberately flips one bit of the checksum byte, so each mismatch costs two cycles. The coherence of the two error-count bytes is also hard to reach. It is exercised by placing a receive mismatch between transmit slots 48 and 56, so that the live low byte differs from the one that has to be sent.

// File: rtl/fo_pkg.sv
// Package fo_pkg
// Frame layout shared by the overhead unit: slot width, byte width,
// overhead slot positions and a classifier for transmit slots.
package fo_pkg;
    localparam int SLOT_W = 8;
    localparam int BYTE_W = 8;

    localparam logic [SLOT_W-1:0] SL_ALIGN = 8'd0;
    localparam logic [SLOT_W-1:0] SL_ASYNC = 8'd8;
    localparam logic [SLOT_W-1:0] SL_CSUM  = 8'd16;
    localparam logic [SLOT_W-1:0] SL_RSV_A = 8'd24;
    localparam logic [SLOT_W-1:0] SL_RSV_B = 8'd32;
    localparam logic [SLOT_W-1:0] SL_RSV_C = 8'd40;
    localparam logic [SLOT_W-1:0] SL_ERRH  = 8'd48;
    localparam logic [SLOT_W-1:0] SL_ERRL  = 8'd56;

    typedef enum logic [2:0] {
        K_NONE, K_ALIGN, K_ASYNC, K_CSUM, K_RSV, K_ERRH, K_ERRL
    } slot_kind_e;

    // Map a slot number to the kind of overhead it carries.
    function automatic slot_kind_e kind_of(input logic [SLOT_W-1:0] s);
        slot_kind_e k;
        case (s)
            SL_ALIGN:                     k = K_ALIGN;
            SL_ASYNC:                     k = K_ASYNC;
            SL_CSUM:                      k = K_CSUM;
            SL_RSV_A, SL_RSV_B, SL_RSV_C: k = K_RSV;
            SL_ERRH:                      k = K_ERRH;
            SL_ERRL:                      k = K_ERRL;
            default:                      k = K_NONE;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/fo_eac_sum.sv
// Module fo_eac_sum
// End-around-carry byte accumulator over one frame.
// Assumes: frame_start marks slot 0, whose byte is excluded. At that slot
// the running value is latched as frame_sum and the accumulator and
// carry are cleared. The carry of the last addition is dropped.
module fo_eac_sum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic         frame_start,
    input  logic [W-1:0] din,
    output logic [W-1:0] frame_sum
);
    logic [W-1:0] acc_q;
    logic         carry_q;
    logic [W:0]   nxt;

    // Next sum: accumulator plus byte plus previous carry.
    always_comb nxt = {1'b0, acc_q} + {1'b0, din} + {{W{1'b0}}, carry_q};

    // Accumulate slots 1..255, latch and restart at slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            carry_q   <= 1'b0;
            frame_sum <= '0;
        end else if (valid) begin
            if (frame_start) begin
                frame_sum <= acc_q;
                acc_q     <= '0;
                carry_q   <= 1'b0;
            end else begin
                acc_q     <= nxt[W-1:0];
                carry_q   <= nxt[W];
            end
        end
    end
endmodule

// File: rtl/fo_async_sampler.sv
// Module fo_async_sampler
// Samples the slow levels once per frame (slot 0) and the fast level
// N_FAST times per frame at evenly spaced slots. A frame's samples are
// published at the next slot 0. The sample taken at slot 0 occupies
// the top bit of pub_fast.
// Assumes: the frame length 2**SLOT_W is a multiple of N_FAST.
module fo_async_sampler #(
    parameter int SLOT_W = 8,
    parameter int N_SLOW = 2,
    parameter int N_FAST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [SLOT_W-1:0] slot,
    input  logic [N_SLOW-1:0] slow_in,
    input  logic              fast_in,
    output logic [N_SLOW-1:0] pub_slow,
    output logic [N_FAST-1:0] pub_fast
);
    localparam int GAP = (1 << SLOT_W) / N_FAST;

    logic [N_SLOW-1:0] slow_q;
    logic [N_FAST-1:0] fast_q;

    for (genvar k = 0; k < N_FAST; k++) begin : g_fast
        localparam logic [SLOT_W-1:0] AT = SLOT_W'(k * GAP);
        logic smp_q;
        // Capture the fast level at this sample slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                    smp_q <= 1'b0;
            else if (valid && slot == AT)  smp_q <= fast_in;
        end
        assign fast_q[N_FAST-1-k] = smp_q;
    end

    // Slow sampling and publication of the finished frame at slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q   <= '0;
            pub_slow <= '0;
            pub_fast <= '0;
        end else if (valid && slot == '0) begin
            slow_q   <= slow_in;
            pub_slow <= slow_q;
            pub_fast <= fast_q;
        end
    end
endmodule

// File: rtl/fo_rx_check.sv
// Module fo_rx_check
// Receive-side checksum checker and remote error count capture.
// Assumes: slot numbering matches the transmit layout. A comparison at
// slot 16 is armed only once a full frame has been summed, i.e. after
// two slot-0 events since reset.
module fo_rx_check
    import fo_pkg::*;
#(
    parameter int W     = 8,
    parameter int ERR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [W-1:0]      rx_byte,
    output logic [ERR_W-1:0]  err_cnt,
    output logic [ERR_W-1:0]  remote_cnt
);
    logic [W-1:0]         rx_sum;
    logic                 seen_q;
    logic                 armed_q;
    logic [ERR_W-W-1:0]   rem_hi_q;
    logic                 miss;

    fo_eac_sum #(.W(W)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (rx_valid),
        .frame_start(rx_slot == SL_ALIGN),
        .din        (rx_byte),
        .frame_sum  (rx_sum)
    );

    // Mismatch between received checksum byte and locally computed sum.
    always_comb miss = rx_valid && armed_q && (rx_slot == SL_CSUM) && (rx_byte != rx_sum);

    // Arm the comparison after a complete frame has been summed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rx_valid && rx_slot == SL_ALIGN) begin
            seen_q  <= 1'b1;
            armed_q <= seen_q;
        end
    end

    // Saturating local error counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_cnt <= '0;
        else if (miss && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
    end

    // Capture the far-end error count, updating both halves together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_hi_q   <= '0;
            remote_cnt <= '0;
        end else if (rx_valid && rx_slot == SL_ERRH) begin
            rem_hi_q   <= rx_byte[ERR_W-W-1:0];
        end else if (rx_valid && rx_slot == SL_ERRL) begin
            remote_cnt <= {rem_hi_q, rx_byte};
        end
    end
endmodule

// File: rtl/frame_ovh_unit.sv
// Module frame_ovh_unit
// Overhead byte source for the reserved aggregate slots plus the
// receive checksum checker. ovh_byte is combinational from the current
// transmit slot and registered state. It is zero on non-overhead or
// invalid slots.
// Assumes: one slot per valid cycle, tx_byte is the byte actually sent.
module frame_ovh_unit
    import fo_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ALIGN_BYTE = 8'hA5,
    parameter logic [BYTE_W-1:0] RSV_BYTE   = 8'h00,
    parameter int                N_SLOW     = 2,
    parameter int                N_FAST     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_valid,
    input  logic [SLOT_W-1:0]   tx_slot,
    input  logic [BYTE_W-1:0]   tx_byte,
    input  logic [N_SLOW-1:0]   slow_in,
    input  logic                fast_in,
    input  logic                far_sync,
    input  logic                near_sync,
    input  logic                rx_valid,
    input  logic [SLOT_W-1:0]   rx_slot,
    input  logic [BYTE_W-1:0]   rx_byte,
    output logic                ovh_hit,
    output logic [BYTE_W-1:0]   ovh_byte,
    output logic [2*BYTE_W-1:0] local_err_cnt,
    output logic [2*BYTE_W-1:0] remote_err_cnt
);
    localparam int ERR_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] tx_sum;
    logic [N_SLOW-1:0] pub_slow;
    logic [N_FAST-1:0] pub_fast;
    logic [BYTE_W-1:0] snap_lo;
    slot_kind_e        kind;

    fo_eac_sum #(.W(BYTE_W)) u_tx_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (tx_valid),
        .frame_start(tx_slot == SL_ALIGN),
        .din        (tx_byte),
        .frame_sum  (tx_sum)
    );

    fo_async_sampler #(.SLOT_W(SLOT_W), .N_SLOW(N_SLOW), .N_FAST(N_FAST)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (tx_valid),
        .slot    (tx_slot),
        .slow_in (slow_in),
        .fast_in (fast_in),
        .pub_slow(pub_slow),
        .pub_fast(pub_fast)
    );

    fo_rx_check #(.W(BYTE_W), .ERR_W(ERR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_slot   (rx_slot),
        .rx_byte   (rx_byte),
        .err_cnt   (local_err_cnt),
        .remote_cnt(remote_err_cnt)
    );

    // Freeze the low count byte when the high byte goes out.
    always_ff @(posedge clk) begin
        if (!rst_n)                            snap_lo <= '0;
        else if (tx_valid && tx_slot == SL_ERRH) snap_lo <= local_err_cnt[BYTE_W-1:0];
    end

    // Select the overhead byte for the current transmit slot.
    always_comb begin
        kind     = kind_of(tx_slot);
        ovh_byte = '0;
        unique case (kind)
            K_ALIGN: ovh_byte = ALIGN_BYTE;
            K_ASYNC: ovh_byte = BYTE_W'({far_sync, near_sync, pub_fast, pub_slow});
            K_CSUM:  ovh_byte = tx_sum;
            K_RSV:   ovh_byte = RSV_BYTE;
            K_ERRH:  ovh_byte = local_err_cnt[ERR_W-1:BYTE_W];
            K_ERRL:  ovh_byte = snap_lo;
            default: ovh_byte = '0;
        endcase
        ovh_hit = tx_valid && (kind != K_NONE);
        if (!tx_valid) ovh_byte = '0;
    end
endmodule

// Module frame_ovh_unit_chk
// Temporal checks on the overhead unit, attached by bind.
module frame_ovh_unit_chk
    import fo_pkg::*;
#(
    parameter int N_FAST = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_valid,
    input logic [SLOT_W-1:0]   tx_slot,
    input logic                rx_valid,
    input logic [SLOT_W-1:0]   rx_slot,
    input logic                ovh_hit,
    input logic [2*BYTE_W-1:0] local_err_cnt,
    input logic [2*BYTE_W-1:0] remote_err_cnt,
    input logic [BYTE_W-1:0]   tx_sum,
    input logic [BYTE_W-1:0]   snap_lo,
    input logic [N_FAST-1:0]   pub_fast
);
    // R3
    csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && tx_slot == SL_ALIGN) |=> $stable(tx_sum));
    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && tx_slot == SL_ERRH) |=> $stable(snap_lo));
    // R7
    err_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_slot == SL_CSUM) |=> $stable(local_err_cnt));
    // R7
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (local_err_cnt == $past(local_err_cnt)
                  || local_err_cnt == (2*BYTE_W)'($past(local_err_cnt) + 1'b1)));
    // R8
    err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_err_cnt == '1) |=> (local_err_cnt == '1));
    // R9
    rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_slot == SL_ERRL) |=> $stable(remote_err_cnt));
    // R10
    pub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> $stable(pub_fast));
    // R2
    hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovh_hit |-> (tx_valid && tx_slot[2:0] == 3'd0 && tx_slot < SLOT_W'(64)));
endmodule

bind frame_ovh_unit frame_ovh_unit_chk #(.N_FAST(N_FAST)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_valid      (tx_valid),
    .tx_slot       (tx_slot),
    .rx_valid      (rx_valid),
    .rx_slot       (rx_slot),
    .ovh_hit       (ovh_hit),
    .local_err_cnt (local_err_cnt),
    .remote_err_cnt(remote_err_cnt),
    .tx_sum        (tx_sum),
    .snap_lo       (snap_lo),
    .pub_fast      (pub_fast)
);

// File: tb/frame_ovh_unit_tb_top.sv
// Scoreboard bench: step() drives one slot, pushes expected items from
// a model built on the requirements, and a monitor pops and compares.
module frame_ovh_unit_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        tx_valid, rx_valid, fast_in, far_sync, near_sync;
    logic [7:0]  tx_slot, tx_byte, rx_slot, rx_byte;
    logic [1:0]  slow_in;
    logic        ovh_hit;
    logic [7:0]  ovh_byte;
    logic [15:0] local_err_cnt, remote_err_cnt;

    frame_ovh_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_slot(tx_slot), .tx_byte(tx_byte),
        .slow_in(slow_in), .fast_in(fast_in), .far_sync(far_sync), .near_sync(near_sync),
        .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_byte(rx_byte),
        .ovh_hit(ovh_hit), .ovh_byte(ovh_byte),
        .local_err_cnt(local_err_cnt), .remote_err_cnt(remote_err_cnt)
    );

    int          kq[$];
    logic [15:0] eq[$];
    string       rq[$];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;

    // Reference model state
    logic [7:0]  t_acc = 0, t_res = 0, snap = 0, r_acc = 0, r_res = 0, r_hi = 0;
    logic        t_c = 0, r_c = 0, r_seen = 0, r_armed = 0;
    logic [1:0]  s_slow = 0, p_slow = 0;
    logic [3:0]  s_fast = 0, p_fast = 0;
    logic [15:0] m_err = 0, m_rem = 0;
    logic [1:0]  nx_slow = 0;
    logic        nx_fast = 0, nx_far = 0, nx_near = 0;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic push(input int k, input logic [15:0] e, input string r);
        kq.push_back(k); eq.push_back(e); rq.push_back(r);
    endtask

    task automatic step(input logic txv, input logic [7:0] txs, input logic [7:0] txb,
                        input logic rxv, input logic [7:0] rxs, input logic [7:0] rxb,
                        input bit c_ovh, input bit c_err, input bit c_rem, input string req);
        logic [8:0] eo;
        logic [8:0] s;
        @(negedge clk);
        tx_valid = txv; tx_slot = txs; tx_byte = txb;
        rx_valid = rxv; rx_slot = rxs; rx_byte = rxb;
        slow_in = nx_slow; fast_in = nx_fast; far_sync = nx_far; near_sync = nx_near;
        eo = 9'h000;
        if (txv) begin
            case (txs)
                8'd0:                eo = {1'b1, 8'hA5};
                8'd8:                eo = {1'b1, nx_far, nx_near, p_fast, p_slow};
                8'd16:               eo = {1'b1, t_res};
                8'd24, 8'd32, 8'd40: eo = 9'h100;
                8'd48:               eo = {1'b1, m_err[15:8]};
                8'd56:               eo = {1'b1, snap};
                default:             eo = 9'h000;
            endcase
        end
        if (c_ovh) push(0, {7'b0, eo}, req);
        if (c_err) push(1, m_err, req);
        if (c_rem) push(2, m_rem, req);
        if (txv) begin
            if (txs == 8'd0) begin
                t_res = t_acc; t_acc = 0; t_c = 0;
                p_slow = s_slow; s_slow = nx_slow;
                p_fast = s_fast; s_fast[3] = nx_fast;
            end else begin
                s = {1'b0, t_acc} + {1'b0, txb} + {8'b0, t_c};
                t_acc = s[7:0]; t_c = s[8];
            end
            if (txs == 8'd64)  s_fast[2] = nx_fast;
            if (txs == 8'd128) s_fast[1] = nx_fast;
            if (txs == 8'd192) s_fast[0] = nx_fast;
            if (txs == 8'd48)  snap = m_err[7:0];
        end
        if (rxv) begin
            if (rxs == 8'd16 && r_armed && rxb != r_res && m_err != 16'hFFFF) m_err = m_err + 1;
            if (rxs == 8'd0) begin
                r_res = r_acc; r_acc = 0; r_c = 0; r_armed = r_seen; r_seen = 1;
            end else begin
                s = {1'b0, r_acc} + {1'b0, rxb} + {8'b0, r_c};
                r_acc = s[7:0]; r_c = s[8];
            end
            if (rxs == 8'd48) r_hi = rxb;
            if (rxs == 8'd56) m_rem = {r_hi, rxb};
        end
    endtask

    function automatic string req_of(input int s);
        case (s)
            16:      return "R3 checksum";
            8:       return "R4 R5 async byte";
            48, 56:  return "R6 error count";
            default: return "R2 slot map";
        endcase
    endfunction

    task automatic run_frame(input int f, input bit corrupt);
        for (int s = 0; s < 256; s++) begin
            logic [7:0] tb_b;
            logic [7:0] rb_b;
            bit         chk;
            tb_b = (f == 2) ? 8'hFF : 8'((s * 37) + (f * 11) + 5);
            rb_b = tb_b;
            if (s == 16) rb_b = r_res ^ (corrupt ? 8'h01 : 8'h00);
            if (s == 48) rb_b = 8'h12 + 8'(f);
            if (s == 56) rb_b = 8'h34 + 8'(f);
            nx_fast = 1'((s >> 6) ^ f ^ (s >> 7));
            nx_slow = 2'(f + 1);
            nx_far  = 1'(f);
            nx_near = ~1'(f);
            chk = (s < 64 && s % 8 == 0) || s == 1 || s == 100;
            step(1'b1, 8'(s), tb_b, 1'b1, 8'(s), rb_b, chk, s == 17, s == 57,
                 s == 17 ? "R7 compare" : (s == 57 ? "R9 remote count" : req_of(s)));
        end
    endtask

    // Monitor: compare queued expectations against outputs mid-cycle.
    initial begin
        int          k;
        logic [15:0] a, e;
        string       r;
        forever begin
            @(negedge clk);
            #5;
            while (kq.size() > 0) begin
                k = kq.pop_front(); e = eq.pop_front(); r = rq.pop_front();
                case (k)
                    0:       a = {7'b0, ovh_hit, ovh_byte};
                    1:       a = local_err_cnt;
                    default: a = remote_err_cnt;
                endcase
                n_checks++;
                if (a !== e) begin
                    n_errors++;
                    $display("FAIL %s: actual %h expected %h", r, a, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        tx_valid = 0; rx_valid = 0; tx_slot = 0; rx_slot = 0; tx_byte = 0; rx_byte = 0;
        slow_in = 0; fast_in = 0; far_sync = 0; near_sync = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step(1, 8'd16, 8'h00, 0, 8'd0, 8'h00, 1, 1, 1, "R1 reset checksum/counts");
        step(1, 8'd8,  8'h00, 0, 8'd0, 8'h00, 1, 0, 0, "R1 reset samples");
        step(1, 8'd0,  8'h00, 0, 8'd0, 8'h00, 1, 0, 0, "R2 alignment");
        step(1, 8'd24, 8'h00, 0, 8'd0, 8'h00, 1, 0, 0, "R2 reserved");
        step(1, 8'd5,  8'h00, 0, 8'd0, 8'h00, 1, 0, 0, "R2 plain slot");
        step(1, 8'd64, 8'h00, 0, 8'd0, 8'h00, 1, 0, 0, "R2 plain slot");

        // R3/R4/R5/R7/R9 full frames; frame 2 is all ones, 3 and 4 corrupt
        run_frame(0, 0);
        run_frame(1, 0);
        run_frame(2, 0);
        run_frame(3, 1);
        run_frame(4, 1);

        // R10 invalid slots change nothing
        step(0, 8'd0,  8'hFF, 0, 8'd16, 8'hEE, 1, 1, 1, "R10 invalid slot");
        step(0, 8'd48, 8'h11, 0, 8'd56, 8'h99, 1, 1, 1, "R10 invalid slot");
        step(0, 8'd64, 8'h22, 0, 8'd0,  8'h00, 0, 0, 0, "");
        step(1, 8'd16, 8'h00, 0, 8'd0,  8'h00, 1, 1, 1, "R10 checksum unchanged");
        step(1, 8'd8,  8'h00, 0, 8'd0,  8'h00, 1, 0, 0, "R10 samples unchanged");

        // R6 low byte frozen while the count moves between slots 48 and 56
        step(1, 8'd48, 8'h00, 1, 8'd0,  8'h00,           1, 1, 0, "R6 high byte");
        step(0, 8'd50, 8'h00, 1, 8'd16, r_res ^ 8'hFF,   0, 0, 0, "");
        step(1, 8'd56, 8'h00, 0, 8'd0,  8'h00,           1, 1, 0, "R6 frozen low byte");

        // R8 saturation using two-slot receive frames
        while (m_err != 16'hFFFF) begin
            step(0, 8'd1, 8'h00, 1, 8'd0,  8'h00,         0, 0, 0, "");
            step(0, 8'd1, 8'h00, 1, 8'd16, r_res ^ 8'h01, 0, 0, 0, "");
        end
        step(0, 8'd1, 8'h00, 0, 8'd0, 8'h00, 0, 1, 0, "R8 reached max");
        for (int i = 0; i < 3; i++) begin
            step(0, 8'd1, 8'h00, 1, 8'd0,  8'h00,         0, 0, 0, "");
            step(0, 8'd1, 8'h00, 1, 8'd16, r_res ^ 8'h01, 0, 0, 0, "");
        end
        step(0, 8'd1, 8'h00, 0, 8'd0, 8'h00, 0, 1, 0, "R8 held at max");

        @(negedge clk);
        #8;
        finish_run();
    end
endmodule